// File: doc/BRIEF.md
# Scrypt Scratchpad Checkpoint Sequencer

This block runs the memory-hard mixing loop of a scrypt-style hash. It stores far less scratchpad than a plain design would and pays for that with extra mixing work. A one-cycle start pulse loads a wide starting state. The fill phase then runs one mixing operation per scratchpad entry, in order. It keeps only the entries whose index is a multiple of a fixed stride, and writes them into a small checkpoint RAM.

The lookup phase runs the same number of mixing operations again. Each one draws an index from the current state. The block rebuilds that scratchpad entry by loading the nearest checkpoint at or below the index and re-applying the mixing step until it reaches the entry. It then folds the rebuilt entry into the state and mixes the result.

A single mixing core with a fixed latency serves the whole loop, and only one operation is in flight at a time. The final state appears together with a one-cycle done pulse. With the default parameters the design holds 1024 entries of 1024 bits with a stride of 64, so the checkpoint RAM has 16 slots. The mixing core takes 32 cycles per operation.

Top module: `scrypt_ckpt_seq`

## Requirements
- R1: While reset is held and after it is released, `busy_o` is 0, `done_o` is 0 and `state_o` is all zeros until the first result.
- R2: A start pulse while idle captures `seed_i` as the working state, and `busy_o` is 1 from the next cycle on.
- R3: The fill phase runs ENTRIES mixing operations; scratchpad entry i is the working state just before operation i, and operation i replaces the state with its mixed value.
- R4: Only entries whose index i satisfies i mod CKPT_STRIDE = 0 are kept, each in checkpoint slot i / CKPT_STRIDE (the upper index bits).
- R5: Each lookup-phase index j is the low log2(ENTRIES) bits of the 32-bit word that starts at bit STATE_W/2 of the working state.
- R6: Entry j is rebuilt from slot j / CKPT_STRIDE by exactly j mod CKPT_STRIDE extra mixing operations; when j mod CKPT_STRIDE is 0 no extra operation is issued.
- R7: Each of the ENTRIES lookup-phase steps sets the working state to mix(state XOR rebuilt entry j).
- R8: The mixing core returns its result MIX_LAT cycles after it is issued and never has two operations outstanding. As a result `done_o` rises exactly N·(L+2) + Σ_j (2 + (r_j+1)·(L+2)) cycles after the edge that samples the start pulse, with N = ENTRIES, L = MIX_LAT and r_j = j mod CKPT_STRIDE.
- R9: `done_o` is high for exactly one cycle, in the cycle where `busy_o` falls. `state_o` carries the final working state in that cycle and holds it unchanged until the next done pulse.
- R10: A start pulse while `busy_o` is 1 has no effect: the running hash keeps its seed, its timing and its single done pulse.
- R11: One mixing step maps 32-bit lane k of an input with M lanes to rotl(w[k] XOR w[(k+1) mod M], 7) + 0x9E3779B9 + k, modulo 2^32. Lane k occupies bits 32k+31 down to 32k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a hash |
| seed_i | input | STATE_W | Starting state, sampled with the start pulse |
| busy_o | output | 1 | High while a hash is running |
| done_o | output | 1 | One-cycle pulse marking a valid result |
| state_o | output | STATE_W | Final working state, held between results |

## Verification
On every cycle the assertions check the following. Done is a single-cycle pulse that coincides with the fall of busy, and the result output stays frozen between pulses. An idle start always raises busy. The internal mixing core never gets a second issue while one is pending, and it answers exactly MIX_LAT cycles after each issue.

Only the bench scenarios can show that the checkpoint placement, the index extraction, the rebuild depth and the XOR-then-mix update give the same final state as a full scratchpad. They do this by comparing against a reference that keeps every entry, for several seeds. The exact start-to-done cycle count in those scenarios shows that each rebuild runs exactly j mod stride operations. A start injected mid-hash shows that it is ignored.

// File: rtl/scrypt_ckpt_pkg.sv
package scrypt_ckpt_pkg;

   localparam int unsigned LANE_W  = 32;
   localparam int unsigned MIX_ROT = 7;
   localparam logic [31:0] MIX_K   = 32'h9E3779B9;

   typedef enum logic [3:0] {
      SQ_IDLE,
      SQ_FILL_GO,
      SQ_FILL_WAIT,
      SQ_PICK,
      SQ_LOAD,
      SQ_REB_GO,
      SQ_REB_WAIT,
      SQ_MIX_GO,
      SQ_MIX_WAIT
   } seq_st_e;

endpackage

// File: rtl/scrypt_mix_core.sv
module scrypt_mix_core
   import scrypt_ckpt_pkg::*;
#(
   parameter int unsigned W   = 1024,
   parameter int unsigned LAT = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go_i,
   input  logic [W-1:0] din_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] dout_o
);

   localparam int unsigned LANES = W / LANE_W;
   localparam int unsigned CW    = $clog2(LAT + 1) + 1;

   if (W % LANE_W != 0) begin : g_bad_w
      $error("scrypt_mix_core: W must be a multiple of the lane width");
   end
   if (LAT < 1) begin : g_bad_lat
      $error("scrypt_mix_core: LAT must be at least 1");
   end

   logic [W-1:0]  mixed;
   logic [CW-1:0] cnt;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] a;
      assign a = din_i[l*LANE_W +: LANE_W] ^ din_i[((l + 1) % LANES)*LANE_W +: LANE_W];
      assign mixed[l*LANE_W +: LANE_W] =
         {a[LANE_W-MIX_ROT-1:0], a[LANE_W-1:LANE_W-MIX_ROT]} + MIX_K + LANE_W'(l);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         busy_o <= 1'b0;
         done_o <= 1'b0;
         dout_o <= '0;
      end else begin
         done_o <= 1'b0;
         if (go_i && !busy_o) begin
            dout_o <= mixed;
            cnt    <= CW'(LAT);
            busy_o <= 1'b1;
         end else if (busy_o) begin
            if (cnt == CW'(1)) begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
            end
            cnt <= cnt - CW'(1);
         end
      end
   end

endmodule

// File: rtl/scrypt_ckpt_ram.sv
module scrypt_ckpt_ram #(
   parameter int unsigned W     = 1024,
   parameter int unsigned SLOTS = 16
) (
   input  logic                     clk,
   input  logic                     we_i,
   input  logic [$clog2(SLOTS)-1:0] waddr_i,
   input  logic [W-1:0]             wdata_i,
   input  logic [$clog2(SLOTS)-1:0] raddr_i,
   output logic [W-1:0]             rdata_o
);

   if (SLOTS < 2) begin : g_bad_slots
      $error("scrypt_ckpt_ram: SLOTS must be at least 2");
   end

   logic [W-1:0] mem [SLOTS];

   always_ff @(posedge clk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
      rdata_o <= mem[raddr_i];
   end

endmodule

// File: rtl/scrypt_ckpt_seq.sv
module scrypt_ckpt_seq
   import scrypt_ckpt_pkg::*;
#(
   parameter int unsigned STATE_W     = 1024,
   parameter int unsigned ENTRIES     = 1024,
   parameter int unsigned CKPT_STRIDE = 64,
   parameter int unsigned MIX_LAT     = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [STATE_W-1:0] seed_i,
   output logic               busy_o,
   output logic               done_o,
   output logic [STATE_W-1:0] state_o
);

   localparam int unsigned IDX_W  = $clog2(ENTRIES);
   localparam int unsigned OFS_W  = $clog2(CKPT_STRIDE);
   localparam int unsigned SLOT_W = IDX_W - OFS_W;
   localparam int unsigned SLOTS  = ENTRIES / CKPT_STRIDE;
   localparam int unsigned HALF   = STATE_W / 2;

   if ((ENTRIES & (ENTRIES - 1)) != 0 || ENTRIES < 4) begin : g_bad_entries
      $error("scrypt_ckpt_seq: ENTRIES must be a power of two, at least 4");
   end
   if ((CKPT_STRIDE & (CKPT_STRIDE - 1)) != 0 || CKPT_STRIDE < 2) begin : g_bad_stride
      $error("scrypt_ckpt_seq: CKPT_STRIDE must be a power of two, at least 2");
   end
   if (CKPT_STRIDE >= ENTRIES) begin : g_bad_ratio
      $error("scrypt_ckpt_seq: CKPT_STRIDE must be below ENTRIES");
   end
   if (STATE_W % 64 != 0) begin : g_bad_state
      $error("scrypt_ckpt_seq: STATE_W must be a multiple of 64");
   end
   if (IDX_W > LANE_W) begin : g_bad_idx
      $error("scrypt_ckpt_seq: index must fit in one 32-bit word");
   end
   if (MIX_LAT < 1) begin : g_bad_lat
      $error("scrypt_ckpt_seq: MIX_LAT must be at least 1");
   end

   seq_st_e             st;
   logic [STATE_W-1:0]  x;
   logic [STATE_W-1:0]  v;
   logic [IDX_W-1:0]    idx;
   logic [OFS_W-1:0]    rem;

   logic                mix_start;
   logic [STATE_W-1:0]  mix_in;
   logic                mix_busy;
   logic                mix_done;
   logic [STATE_W-1:0]  mix_out;

   logic                ram_we;
   logic [SLOT_W-1:0]   ram_waddr;
   logic [SLOT_W-1:0]   ram_raddr;
   logic [STATE_W-1:0]  ram_rdata;
   logic                last_op;

   always_comb begin
      mix_start = (st == SQ_FILL_GO) || (st == SQ_REB_GO) || (st == SQ_MIX_GO);
      unique case (st)
         SQ_REB_GO: mix_in = v;
         SQ_MIX_GO: mix_in = x ^ v;
         default:   mix_in = x;
      endcase
      ram_we    = (st == SQ_FILL_GO) && (idx[OFS_W-1:0] == '0);
      ram_waddr = idx[IDX_W-1:OFS_W];
      ram_raddr = x[HALF+OFS_W +: SLOT_W];
      last_op   = (idx == IDX_W'(ENTRIES - 1));
      busy_o    = (st != SQ_IDLE);
   end

   scrypt_mix_core #(
      .W   (STATE_W),
      .LAT (MIX_LAT)
   ) u_mix (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (mix_start),
      .din_i  (mix_in),
      .busy_o (mix_busy),
      .done_o (mix_done),
      .dout_o (mix_out)
   );

   scrypt_ckpt_ram #(
      .W     (STATE_W),
      .SLOTS (SLOTS)
   ) u_ram (
      .clk     (clk),
      .we_i    (ram_we),
      .waddr_i (ram_waddr),
      .wdata_i (x),
      .raddr_i (ram_raddr),
      .rdata_o (ram_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= SQ_IDLE;
         x       <= '0;
         v       <= '0;
         idx     <= '0;
         rem     <= '0;
         done_o  <= 1'b0;
         state_o <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (st)
            SQ_IDLE: begin
               if (start_i) begin
                  x   <= seed_i;
                  idx <= '0;
                  st  <= SQ_FILL_GO;
               end
            end
            SQ_FILL_GO: st <= SQ_FILL_WAIT;
            SQ_FILL_WAIT: begin
               if (mix_done) begin
                  x   <= mix_out;
                  idx <= idx + IDX_W'(1);
                  st  <= last_op ? SQ_PICK : SQ_FILL_GO;
               end
            end
            SQ_PICK: begin
               rem <= x[HALF +: OFS_W];
               st  <= SQ_LOAD;
            end
            SQ_LOAD: begin
               v  <= ram_rdata;
               st <= (rem == '0) ? SQ_MIX_GO : SQ_REB_GO;
            end
            SQ_REB_GO: st <= SQ_REB_WAIT;
            SQ_REB_WAIT: begin
               if (mix_done) begin
                  v   <= mix_out;
                  rem <= rem - OFS_W'(1);
                  st  <= (rem == OFS_W'(1)) ? SQ_MIX_GO : SQ_REB_GO;
               end
            end
            SQ_MIX_GO: st <= SQ_MIX_WAIT;
            SQ_MIX_WAIT: begin
               if (mix_done) begin
                  x   <= mix_out;
                  idx <= idx + IDX_W'(1);
                  if (last_op) begin
                     st      <= SQ_IDLE;
                     done_o  <= 1'b1;
                     state_o <= mix_out;
                  end else begin
                     st <= SQ_PICK;
                  end
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/scrypt_ckpt_chk.sv
module scrypt_ckpt_chk #(
   parameter int unsigned W   = 1024,
   parameter int unsigned LAT = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic         busy_o,
   input logic         done_o,
   input logic [W-1:0] state_o,
   input logic         mix_start,
   input logic         mix_busy,
   input logic         mix_done
);

   localparam int unsigned CW = $clog2(LAT + 2) + 1;

   logic [CW-1:0] since;

   always_ff @(posedge clk) begin
      if (!rst_n)                since <= '1;
      else if (mix_start)        since <= '0;
      else if (since != '1)      since <= since + CW'(1);
   end

   AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o); // R2
   AST_MIX_SINGLE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      mix_start |-> !mix_busy); // R8
   AST_MIX_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      mix_done |-> (since == CW'(LAT))); // R8
   AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9
   AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o))); // R9
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(state_o)); // R9

endmodule

bind scrypt_ckpt_seq scrypt_ckpt_chk #(
   .W   (STATE_W),
   .LAT (MIX_LAT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .state_o   (state_o),
   .mix_start (mix_start),
   .mix_busy  (mix_busy),
   .mix_done  (mix_done)
);

// File: tb/sim_scrypt_ckpt_seq.sv
`timescale 1ns/1ps
module sim_scrypt_ckpt_seq;

   localparam int W = 1024;
   localparam int N = 64;
   localparam int S = 8;
   localparam int L = 4;
   localparam int M = W / 32;

   typedef struct {
      logic [W-1:0] st;
      int           cyc;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [W-1:0] seed_i = '0;
   logic         busy_o;
   logic         done_o;
   logic [W-1:0] state_o;

   int   errors = 0;
   int   checks = 0;
   int   cyc = 0;
   int   t0 = 0;
   int   pushed = 0;
   int   seen = 0;
   bit   pend = 1'b0;
   bit   finished = 1'b0;
   logic [W-1:0] held = '0;
   exp_t q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   scrypt_ckpt_seq #(
      .STATE_W     (W),
      .ENTRIES     (N),
      .CKPT_STRIDE (S),
      .MIX_LAT     (L)
   ) u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .seed_i  (seed_i),
      .busy_o  (busy_o),
      .done_o  (done_o),
      .state_o (state_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // R11: lane k -> rotl(w[k] ^ w[k+1 mod M], 7) + 0x9E3779B9 + k
   function automatic logic [W-1:0] mix_ref(input logic [W-1:0] a);
      logic [W-1:0] r;
      for (int k = 0; k < M; k++) begin
         logic [31:0] t;
         t = a[k*32 +: 32] ^ a[((k + 1) % M)*32 +: 32];
         r[k*32 +: 32] = {t[24:0], t[31:25]} + 32'h9E3779B9 + 32'(k);
      end
      return r;
   endfunction

   // Full-scratchpad reference: R3, R5, R7; cycle total from R6 and R8.
   task automatic ref_run(input logic [W-1:0] seed, output logic [W-1:0] res, output int c);
      logic [W-1:0] pad [N];
      logic [W-1:0] xs;
      xs = seed;
      c  = 0;
      for (int i = 0; i < N; i++) begin
         pad[i] = xs;
         xs = mix_ref(xs);
         c += L + 2;
      end
      for (int i = 0; i < N; i++) begin
         int j;
         j  = int'(xs[W/2 +: 6]);
         xs = mix_ref(xs ^ pad[j]);
         c += 2 + ((j % S) + 1) * (L + 2);
      end
      res = xs;
   endtask

   task automatic run_hash(input logic [W-1:0] seed, input bit poke);
      exp_t e;
      while (busy_o) @(negedge clk);
      ref_run(seed, e.st, e.cyc);
      q.push_back(e);
      pushed++;
      @(negedge clk);
      seed_i  = seed;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      t0 = cyc;
      check(busy_o === 1'b1, "R2", "busy after start", W'(busy_o), W'(1));
      if (poke) begin
         repeat (40) @(negedge clk);
         seed_i  = ~seed;
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         check(busy_o === 1'b1, "R10", "busy after ignored start", W'(busy_o), W'(1));
      end
      while (seen < pushed) @(negedge clk);
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (pend) begin
            pend = 1'b0;
            check(done_o === 1'b0, "R9", "done width", W'(done_o), W'(0));
            check(state_o === held, "R9", "result held", state_o, held);
         end
         if (done_o === 1'b1) begin
            if (q.size() == 0) begin
               check(1'b0, "R10", "unexpected done", W'(1), W'(0));
            end else begin
               exp_t e;
               e = q.pop_front();
               check(state_o === e.st, "R3 R4 R5 R6 R7 R11", "final state", state_o, e.st);
               check((cyc - t0) == e.cyc, "R6 R8", "start-to-done cycles",
                     W'(cyc - t0), W'(e.cyc));
            end
            held = state_o;
            pend = 1'b1;
            seen++;
         end
      end
   end

   initial begin
      logic [W-1:0] cnt_seed;
      for (int k = 0; k < M; k++) cnt_seed[k*32 +: 32] = 32'(k * 7 + 3);
      repeat (4) @(negedge clk);
      check(busy_o === 1'b0, "R1", "busy in reset", W'(busy_o), W'(0));
      check(done_o === 1'b0, "R1", "done in reset", W'(done_o), W'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check(state_o === '0, "R1", "state after reset", state_o, '0);
      check(busy_o === 1'b0, "R1", "busy after reset", W'(busy_o), W'(0));

      run_hash('0, 1'b0);
      run_hash('1, 1'b0);
      run_hash({32{32'h01234567}}, 1'b0);
      run_hash({16{64'hDEADBEEF_0BADF00D}}, 1'b1);
      run_hash(cnt_seed, 1'b0);
      run_hash({32{32'hA5A55A5A}}, 1'b1);

      repeat (20) @(negedge clk);
      check(state_o === held, "R9", "result held while idle", state_o, held);
      check(seen == pushed, "R10", "done count", W'(seen), W'(pushed));

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule